// File: doc/BRIEF.md
# Epoch Checkpoint and Rollback Controller

This block sequences a small pipelined datapath through computational epochs. While an epoch runs, every result the datapath writes lands in a speculative state register. One built-in tester per pipeline stage checks that stage's hardware alongside normal work. Each tester reports a completion pulse and, if it finds a defect, a fault. An epoch-length counter ends the compute window. The controller then stalls the datapath until every enabled tester has reported completion.

If the testing is clean, the speculative value becomes the new checkpoint. If any enabled tester flags a defect, the controller throws the speculative value away and restores it from the checkpoint. It then adds the faulty stage to a sticky disable mask and resumes computing in a degraded mode rather than halting. External I/O and interrupt requests are never acted on speculatively. They are held until a validated checkpoint boundary and granted there.

Top module: `ckpt_epoch_ctrl`

## Requirements
- R1: Reset is synchronous and active low. During and after reset:
  - `phase` is 0 (compute);
  - `spec_state`, `ckpt_state` and `unit_disable` are 0;
  - `stall`, `commit_pulse`, `rollback_pulse`, `ext_grant` and `degraded` are 0.
- R2: Each compute window lasts exactly EPOCH_LEN clock cycles unless a fault cuts it short. After it, `phase` becomes 1 (wait for tests) and `stall` is 1.
- R3: A write (`spec_we`=1) is stored in `spec_state` at the next clock edge only when `phase` is 0. In every other phase the write has no effect.
- R4: In the wait phase the controller goes to commit (`phase`=2, `commit_pulse`=1 for one cycle) once every stage not disabled has pulsed its `stage_done` bit in this epoch, with no fault. If a done pulse is still missing, it stays in the wait phase.
- R5: `ckpt_state` takes the value of `spec_state` at the edge that ends the commit cycle. At no other time does `ckpt_state` change.
- R6: A `stage_fault` bit of an enabled stage, seen in the compute or wait phase, moves the controller to rollback at the next edge (`phase`=3, `rollback_pulse`=1 for one cycle). At the end of the rollback cycle `spec_state` is reloaded from `ckpt_state`. A reconfigure cycle (`phase`=4) follows, and then computing resumes.
- R7: A fault arriving in the same cycle as the last missing done pulse causes rollback, not commit.
- R8: At the end of the reconfigure cycle, the faulting stages are ORed into `unit_disable` (bit i is stage i). The mask is sticky: only reset clears it. `degraded` is 1 whenever any mask bit is set.
- R9: Done and fault reports from disabled stages are ignored. They cause no rollback, and a commit does not wait for them.
- R10: An `ext_req` pulse is held pending, including across rollbacks. It is granted (`ext_grant`=1) only in a commit cycle.
- R11: The `phase` encoding is: compute 0, wait for tests 1, commit 2, rollback 3, reconfigure 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spec_we | input | 1 | Datapath write strobe for speculative state |
| spec_wdata | input | STATE_W | Datapath write value |
| stage_done | input | NUM_STAGES | Per-stage tester completion pulses |
| stage_fault | input | NUM_STAGES | Per-stage tester defect reports |
| ext_req | input | 1 | Non-speculative I/O or interrupt request pulse |
| phase | output | 3 | Controller phase code (R11) |
| stall | output | 1 | Datapath must hold (any phase but compute) |
| spec_state | output | STATE_W | Speculative state |
| ckpt_state | output | STATE_W | Last committed checkpoint |
| commit_pulse | output | 1 | High during the commit cycle |
| rollback_pulse | output | 1 | High during the rollback cycle |
| unit_disable | output | NUM_STAGES | Sticky disabled-stage mask |
| degraded | output | 1 | At least one stage disabled |
| ext_grant | output | 1 | Pending external request granted at a checkpoint |

## Verification
Timing after a stimulus:
- A speculative write driven in a compute cycle shows on `spec_state` one edge later.
- A fault from an enabled stage raises `rollback_pulse` one edge later. The restored `spec_state` appears one edge after that, and the widened mask one more edge later.
- The last done pulse in the wait phase gives `commit_pulse` one edge later, and the new `ckpt_state` the edge after.

The bench drives inputs at falling edges and samples outputs at the next falling edge, counting exactly these edges. A scoreboard queue holds the expected commit and rollback events, each with the value that must be visible when its pulse appears.

// File: rtl/ckpt_pkg.sv
// Package: shared phase encoding for the epoch checkpoint controller.
// Assumes: the codes are visible on the top-level phase port and are fixed.
package ckpt_pkg;
    typedef enum logic [2:0] {
        PH_COMPUTE  = 3'd0,
        PH_WAIT     = 3'd1,
        PH_COMMIT   = 3'd2,
        PH_ROLLBACK = 3'd3,
        PH_RECONFIG = 3'd4
    } phase_e;
endpackage

// File: rtl/ckpt_epoch_timer.sv
// Module: counts the cycles of one compute window.
// Flags the final cycle so the sequencer can leave the compute phase.
// Assumes: EPOCH_LEN >= 2. The count restarts whenever run is low.
module ckpt_epoch_timer #(
    parameter int EPOCH_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (EPOCH_LEN > 2) ? $clog2(EPOCH_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(EPOCH_LEN - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: advance while computing, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_VAL);
endmodule

// File: rtl/ckpt_test_collector.sv
// Module: gathers per-stage tester reports over one epoch.
// It produces a fault verdict and an all-done verdict. Disabled stages are
// masked out of both verdicts.
// Assumes: reports are only meaningful while 'listen' is high; the sticky
// records are cleared by 'clear_all'.
module ckpt_test_collector #(
    parameter int NUM_STAGES = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  listen,
    input  logic                  clear_all,
    input  logic [NUM_STAGES-1:0] dis_mask,
    input  logic [NUM_STAGES-1:0] done_in,
    input  logic [NUM_STAGES-1:0] fault_in,
    output logic [NUM_STAGES-1:0] fault_rec,
    output logic                  fault_now,
    output logic                  all_done_now
);
    logic [NUM_STAGES-1:0] done_rec;
    logic [NUM_STAGES-1:0] done_cover;
    logic [NUM_STAGES-1:0] fault_hit;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        // Purpose: per-stage sticky done and fault records for the epoch.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                done_rec[s]  <= 1'b0;
                fault_rec[s] <= 1'b0;
            end else if (listen && !dis_mask[s]) begin
                done_rec[s]  <= done_rec[s] | done_in[s];
                fault_rec[s] <= fault_rec[s] | fault_in[s];
            end
        end

        assign fault_hit[s]  = listen && !dis_mask[s] && fault_in[s];
        assign done_cover[s] = dis_mask[s] || done_rec[s] || (listen && done_in[s]);
    end

    assign fault_now    = |fault_hit;
    assign all_done_now = &done_cover;
endmodule

// File: rtl/ckpt_state_store.sv
// Module: holds the speculative state and the committed checkpoint.
// Assumes: accept, commit and restore are mutually exclusive one-cycle
// controls from the sequencer.
module ckpt_state_store #(
    parameter int STATE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_data,
    input  logic               commit,
    input  logic               restore,
    output logic [STATE_W-1:0] spec_q,
    output logic [STATE_W-1:0] ckpt_q
);
    // Purpose: speculative register, written in compute, reloaded on rollback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q <= '0;
        end else if (restore) begin
            spec_q <= ckpt_q;
        end else if (accept && wr_en) begin
            spec_q <= wr_data;
        end
    end

    // Purpose: checkpoint register, updated only when an epoch validates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ckpt_q <= '0;
        end else if (commit) begin
            ckpt_q <= spec_q;
        end
    end
endmodule

// File: rtl/ckpt_phase_fsm.sv
// Module: epoch sequencer FSM.
// Sequence: compute, wait for tests, then commit or rollback, then
// reconfigure. A fault takes priority over commit.
// Assumes: verdict inputs are combinational from the collector in the same cycle.
module ckpt_phase_fsm
    import ckpt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   window_end,
    input  logic   fault_now,
    input  logic   all_done_now,
    output phase_e ph
);
    phase_e ph_nx;

    // Purpose: next-phase decision.
    always_comb begin
        ph_nx = ph;
        unique case (ph)
            PH_COMPUTE: begin
                if (fault_now)       ph_nx = PH_ROLLBACK;
                else if (window_end) ph_nx = PH_WAIT;
            end
            PH_WAIT: begin
                if (fault_now)         ph_nx = PH_ROLLBACK;
                else if (all_done_now) ph_nx = PH_COMMIT;
            end
            PH_COMMIT:   ph_nx = PH_COMPUTE;
            PH_ROLLBACK: ph_nx = PH_RECONFIG;
            PH_RECONFIG: ph_nx = PH_COMPUTE;
            default:     ph_nx = PH_COMPUTE;
        endcase
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_COMPUTE;
        else        ph <= ph_nx;
    end
endmodule

// File: rtl/ckpt_epoch_ctrl.sv
// Module: top of the epoch checkpoint and rollback controller.
// It ties together the timer, the tester collector, the state store and the
// sequencer. It also owns the sticky disable mask and the pending external request.
// Assumes: per-stage testers and the datapath are external. Inputs are
// synchronous to clk.
module ckpt_epoch_ctrl
    import ckpt_pkg::*;
#(
    parameter int NUM_STAGES = 5,
    parameter int STATE_W    = 8,
    parameter int EPOCH_LEN  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spec_we,
    input  logic [STATE_W-1:0]    spec_wdata,
    input  logic [NUM_STAGES-1:0] stage_done,
    input  logic [NUM_STAGES-1:0] stage_fault,
    input  logic                  ext_req,
    output logic [2:0]            phase,
    output logic                  stall,
    output logic [STATE_W-1:0]    spec_state,
    output logic [STATE_W-1:0]    ckpt_state,
    output logic                  commit_pulse,
    output logic                  rollback_pulse,
    output logic [NUM_STAGES-1:0] unit_disable,
    output logic                  degraded,
    output logic                  ext_grant
);
    phase_e                ph;
    logic                  in_compute;
    logic                  listening;
    logic                  in_commit;
    logic                  in_rollback;
    logic                  in_reconfig;
    logic                  window_end;
    logic                  fault_now;
    logic                  all_done_now;
    logic [NUM_STAGES-1:0] fault_rec;
    logic [NUM_STAGES-1:0] dis_q;
    logic                  ext_pend;

    assign in_compute  = (ph == PH_COMPUTE);
    assign listening   = (ph == PH_COMPUTE) || (ph == PH_WAIT);
    assign in_commit   = (ph == PH_COMMIT);
    assign in_rollback = (ph == PH_ROLLBACK);
    assign in_reconfig = (ph == PH_RECONFIG);

    ckpt_epoch_timer #(.EPOCH_LEN(EPOCH_LEN)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_compute),
        .last (window_end)
    );

    ckpt_test_collector #(.NUM_STAGES(NUM_STAGES)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .listen      (listening),
        .clear_all   (in_commit || in_reconfig),
        .dis_mask    (dis_q),
        .done_in     (stage_done),
        .fault_in    (stage_fault),
        .fault_rec   (fault_rec),
        .fault_now   (fault_now),
        .all_done_now(all_done_now)
    );

    ckpt_state_store #(.STATE_W(STATE_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (in_compute),
        .wr_en  (spec_we),
        .wr_data(spec_wdata),
        .commit (in_commit),
        .restore(in_rollback),
        .spec_q (spec_state),
        .ckpt_q (ckpt_state)
    );

    ckpt_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .window_end  (window_end),
        .fault_now   (fault_now),
        .all_done_now(all_done_now),
        .ph          (ph)
    );

    // Purpose: sticky disable mask, widened with faulting stages at reconfigure.
    always_ff @(posedge clk) begin
        if (!rst_n)           dis_q <= '0;
        else if (in_reconfig) dis_q <= dis_q | fault_rec;
    end

    // Purpose: hold external requests until a validated checkpoint boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         ext_pend <= 1'b0;
        else if (in_commit) ext_pend <= ext_req;
        else                ext_pend <= ext_pend | ext_req;
    end

    assign phase          = ph;
    assign stall          = !in_compute;
    assign commit_pulse   = in_commit;
    assign rollback_pulse = in_rollback;
    assign unit_disable   = dis_q;
    assign degraded       = |dis_q;
    assign ext_grant      = in_commit && ext_pend;
endmodule

// File: rtl/ckpt_epoch_ctrl_chk.sv
// Module: assertion checker bound to ckpt_epoch_ctrl. It observes ports only.
module ckpt_epoch_ctrl_chk #(
    parameter int NUM_STAGES = 5,
    parameter int STATE_W    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  spec_we,
    input logic [NUM_STAGES-1:0] stage_fault,
    input logic [2:0]            phase,
    input logic                  stall,
    input logic [STATE_W-1:0]    spec_state,
    input logic [STATE_W-1:0]    ckpt_state,
    input logic                  commit_pulse,
    input logic                  rollback_pulse,
    input logic [NUM_STAGES-1:0] unit_disable,
    input logic                  ext_grant
);
    AST_STALL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !rollback_pulse) |=> $stable(spec_state)); // R3
    AST_CKPT_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pulse |=> $stable(ckpt_state)); // R5
    AST_ROLLBACK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_pulse |=> (spec_state == $past(ckpt_state))); // R6
    AST_FAULT_BEATS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 3'd1) && |(stage_fault & ~unit_disable)) |=> rollback_pulse); // R7
    AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((unit_disable & $past(unit_disable)) == $past(unit_disable))); // R8
    AST_GRANT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ext_grant |-> commit_pulse); // R10
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_pulse, rollback_pulse})); // R4
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd4); // R11
endmodule

bind ckpt_epoch_ctrl ckpt_epoch_ctrl_chk #(
    .NUM_STAGES(NUM_STAGES),
    .STATE_W   (STATE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .spec_we       (spec_we),
    .stage_fault   (stage_fault),
    .phase         (phase),
    .stall         (stall),
    .spec_state    (spec_state),
    .ckpt_state    (ckpt_state),
    .commit_pulse  (commit_pulse),
    .rollback_pulse(rollback_pulse),
    .unit_disable  (unit_disable),
    .ext_grant     (ext_grant)
);

// File: tb/sim_ckpt_epoch_ctrl.sv
module sim_ckpt_epoch_ctrl;
    localparam int NS = 5;
    localparam int SW = 8;
    localparam int EL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spec_we = 1'b0;
    logic [SW-1:0] spec_wdata = '0;
    logic [NS-1:0] stage_done = '0;
    logic [NS-1:0] stage_fault = '0;
    logic          ext_req = 1'b0;
    logic [2:0]    phase;
    logic          stall;
    logic [SW-1:0] spec_state;
    logic [SW-1:0] ckpt_state;
    logic          commit_pulse;
    logic          rollback_pulse;
    logic [NS-1:0] unit_disable;
    logic          degraded;
    logic          ext_grant;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic          is_commit;
        logic [SW-1:0] val;
        logic          io;
    } ev_t;
    ev_t expq[$];

    always #5 clk = ~clk;

    ckpt_epoch_ctrl #(.NUM_STAGES(NS), .STATE_W(SW), .EPOCH_LEN(EL)) u0 (
        .clk(clk), .rst_n(rst_n), .spec_we(spec_we), .spec_wdata(spec_wdata),
        .stage_done(stage_done), .stage_fault(stage_fault), .ext_req(ext_req),
        .phase(phase), .stall(stall), .spec_state(spec_state),
        .ckpt_state(ckpt_state), .commit_pulse(commit_pulse),
        .rollback_pulse(rollback_pulse), .unit_disable(unit_disable),
        .degraded(degraded), .ext_grant(ext_grant)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic wait_phase(input logic [2:0] p, input string req);
        int n = 0;
        while (phase !== p && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk_eq(req, 32'(phase), 32'(p));
    endtask

    task automatic push_ev(input logic c, input logic [SW-1:0] v, input logic io);
        ev_t e;
        e.is_commit = c;
        e.val = v;
        e.io = io;
        expq.push_back(e);
    endtask

    // Monitor: pops expected events and compares when a pulse appears.
    always @(negedge clk) begin
        if (rst_n && (commit_pulse || rollback_pulse)) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4/R6 unexpected event", {30'd0, commit_pulse, rollback_pulse}, 32'd0);
            end else begin
                ev_t e;
                e = expq.pop_front();
                chk_eq("R4/R6 event kind", 32'(commit_pulse), 32'(e.is_commit));
                if (e.is_commit) begin
                    chk_eq("R5 commit value", 32'(spec_state), 32'(e.val));
                    chk_eq("R10 grant at commit", 32'(ext_grant), 32'(e.io));
                end else begin
                    chk_eq("R6 restore value", 32'(ckpt_state), 32'(e.val));
                end
            end
        end
        if (rst_n && ext_grant && !commit_pulse)
            chk(1'b0, "R10 grant outside commit", 32'd1, 32'd0);
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 and R11: reset state
        chk_eq("R1 phase", 32'(phase), 32'd0);
        chk_eq("R1 spec", 32'(spec_state), 32'd0);
        chk_eq("R1 ckpt", 32'(ckpt_state), 32'd0);
        chk_eq("R1 mask", 32'(unit_disable), 32'd0);
        chk_eq("R1 flags", {28'd0, stall, commit_pulse, rollback_pulse, ext_grant}, 32'd0);

        // Epoch 1: clean commit (R2, R3, R4)
        rst_n = 1'b1; spec_we = 1'b1; spec_wdata = 8'hA5;
        @(negedge clk);
        spec_we = 1'b0;
        chk_eq("R3 write in compute", 32'(spec_state), 32'hA5);
        stage_done = '1;
        @(negedge clk);
        stage_done = '0;
        repeat (EL - 3) @(negedge clk);
        chk_eq("R2 still compute", 32'(phase), 32'd0);
        @(negedge clk);
        chk_eq("R2 wait after window", 32'(phase), 32'd1);
        chk_eq("R2 stall", 32'(stall), 32'd1);
        push_ev(1'b1, 8'hA5, 1'b0);
        @(negedge clk);
        chk_eq("R11 commit code", 32'(phase), 32'd2);
        @(negedge clk);
        chk_eq("R5 ckpt updated", 32'(ckpt_state), 32'hA5);
        chk_eq("R11 compute code", 32'(phase), 32'd0);

        // Epoch 2: partial done holds wait, writes ignored, request deferred
        spec_we = 1'b1; spec_wdata = 8'h11;
        @(negedge clk);
        spec_we = 1'b0;
        wait_phase(3'd1, "R2 reach wait");
        spec_we = 1'b1; spec_wdata = 8'h3C; ext_req = 1'b1; stage_done = 5'b01111;
        @(negedge clk);
        spec_we = 1'b0; ext_req = 1'b0; stage_done = '0;
        chk_eq("R4 stays waiting", 32'(phase), 32'd1);
        chk_eq("R3 write ignored in wait", 32'(spec_state), 32'h11);
        chk_eq("R5 ckpt unchanged", 32'(ckpt_state), 32'hA5);
        chk_eq("R10 no early grant", 32'(ext_grant), 32'd0);
        push_ev(1'b1, 8'h11, 1'b1);
        stage_done = 5'b10000;
        @(negedge clk);
        stage_done = '0;
        @(negedge clk);
        chk_eq("R5 ckpt epoch2", 32'(ckpt_state), 32'h11);

        // Epoch 3: fault in compute on stage 2 -> rollback (R6, R8, R10)
        spec_we = 1'b1; spec_wdata = 8'h77; ext_req = 1'b1;
        @(negedge clk);
        spec_we = 1'b0; ext_req = 1'b0;
        push_ev(1'b0, 8'h11, 1'b0);
        stage_fault = 5'b00100;
        @(negedge clk);
        stage_fault = '0;
        chk_eq("R6 rollback code", 32'(phase), 32'd3);
        @(negedge clk);
        chk_eq("R6 reconfig code", 32'(phase), 32'd4);
        chk_eq("R6 spec restored", 32'(spec_state), 32'h11);
        @(negedge clk);
        chk_eq("R8 mask set", 32'(unit_disable), 32'b00100);
        chk_eq("R8 degraded", 32'(degraded), 32'd1);
        chk_eq("R6 resumes compute", 32'(phase), 32'd0);

        // Epoch 4: fault together with last done -> rollback (R7)
        spec_we = 1'b1; spec_wdata = 8'h5E;
        @(negedge clk);
        spec_we = 1'b0; stage_done = 5'b01011;
        @(negedge clk);
        stage_done = '0;
        wait_phase(3'd1, "R2 reach wait e4");
        @(negedge clk);
        chk_eq("R4 waits for stage 4", 32'(phase), 32'd1);
        push_ev(1'b0, 8'h11, 1'b0);
        stage_done = 5'b10000; stage_fault = 5'b01000;
        @(negedge clk);
        stage_done = '0; stage_fault = '0;
        chk_eq("R7 rollback wins", 32'(phase), 32'd3);
        chk_eq("R7 no commit", 32'(commit_pulse), 32'd0);
        repeat (2) @(negedge clk);
        chk_eq("R8 mask grows", 32'(unit_disable), 32'b01100);

        // Epoch 5: disabled stage fault ignored, commit without it (R9, R10)
        spec_we = 1'b1; spec_wdata = 8'h42;
        @(negedge clk);
        spec_we = 1'b0;
        push_ev(1'b1, 8'h42, 1'b1);
        stage_done = 5'b10011; stage_fault = 5'b00100;
        @(negedge clk);
        stage_done = '0; stage_fault = '0;
        chk_eq("R9 no rollback", 32'(phase), 32'd0);
        wait_phase(3'd2, "R9 commit reached");
        @(negedge clk);
        chk_eq("R9 ckpt", 32'(ckpt_state), 32'h42);
        chk_eq("R8 mask sticky", 32'(unit_disable), 32'b01100);

        // Reset clears the mask (R1, R8)
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R8 mask cleared by reset", 32'(unit_disable), 32'd0);
        chk_eq("R1 degraded after reset", 32'(degraded), 32'd0);
        chk_eq("R1 ckpt after reset", 32'(ckpt_state), 32'd0);
        chk_eq("R4 queue drained", 32'(expq.size()), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule